// File: doc/BRIEF.md
# Calendar Alarm Comparator

The block watches a running BCD clock and raises a sticky alarm flag when the clock reaches a programmed alarm setting. A calendar counter outside the block supplies the current seconds, minutes, hours with a PM bit, the day of the month, the weekday and a binary sub-second count. The alarm setting gives the same BCD fields plus a sub-second value. Each of the seconds, minutes, hours and day groups has its own don't-care mask. A select bit decides whether the alarm day field is compared against the date or against the weekday. A count input sets how many low bits of the sub-second value take part in the comparison.

An alarm enable gates the setting of the flag, and an interrupt enable gates the interrupt request that the flag drives. Software clears the flag with a one-cycle write-one-to-clear strobe. A chip with two alarms uses two instances of the block.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset the flag and the interrupt request are both 0.
- R2: With no group masked and the sub-second count at 0, the flag is set only when seconds, minutes, hours, PM bit and the day field all equal the alarm fields. It is then 1 from the cycle after the clock edge where the equality is first seen.
- R3: A set mask bit removes its group (seconds, minutes, hours with PM, or day) from the comparison. A clear mask bit keeps it.
- R4: The hour comparison includes the PM bit (0 means AM or 24-hour, 1 means PM). Hours that are equal but have different PM bits do not match.
- R5: With the weekday select at 0, all six day bits are compared against the date (tens in bits 5:4, units in bits 3:0). With the select at 1, alarm day bits 3:0 are compared against the weekday (1 to 7), and the date is not used at all.
- R6: The sub-second count N (0 to 15) compares bits N-1:0 of the sub-second value against the alarm. N = 0 leaves the sub-second value out of the comparison.
- R7: The flag is set only when the enabled match changes from false to true. A match that is held does not set the flag again after a clear.
- R8: While the alarm enable is 0, the flag is never set.
- R9: Setting the alarm enable to 0 does not clear a flag that is already set.
- R10: The interrupt request equals the flag ANDed with the interrupt enable, in the same cycle.
- R11: A 1 on the clear strobe clears the flag at the next edge.
- R12: When a new match event and the clear strobe arrive in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curSec | input | 7 | Current seconds, tens bits 6:4 and units bits 3:0 |
| curMin | input | 7 | Current minutes, tens bits 6:4 and units bits 3:0 |
| curHour | input | 6 | Current hours, tens bits 5:4 and units bits 3:0 |
| curPm | input | 1 | Current PM bit |
| curDate | input | 6 | Current date, tens bits 5:4 and units bits 3:0 |
| curWday | input | 4 | Current weekday, 1 to 7 |
| curSubSec | input | SUBSEC_W | Current sub-second count |
| almSec | input | 7 | Alarm seconds |
| almMin | input | 7 | Alarm minutes |
| almHour | input | 6 | Alarm hours |
| almPm | input | 1 | Alarm PM bit |
| almDay | input | 6 | Alarm date, or weekday in bits 3:0 |
| almWdSel | input | 1 | 1 selects weekday comparison |
| maskSec | input | 1 | Seconds don't-care |
| maskMin | input | 1 | Minutes don't-care |
| maskHour | input | 1 | Hours don't-care |
| maskDay | input | 1 | Day don't-care |
| almSubSec | input | SUBSEC_W | Alarm sub-second value |
| subSecBits | input | CNT_W | Number of low sub-second bits compared |
| almEn | input | 1 | Alarm enable |
| irqEn | input | 1 | Interrupt enable |
| clrStrobe | input | 1 | Write-one-to-clear pulse for the flag |
| almFlag | output | 1 | Sticky alarm flag |
| almIrq | output | 1 | Interrupt request |

## Verification
The comparator is driven with full matches, and with mismatches that sit in only one field. This shows that each group is really compared. Each mask is then set against its own mismatching field, which separates a mask that works from one that masks the wrong group. The PM bit, the date and weekday views of the day field, and several sub-second counts (0, 4, 15) are each made to differ alone, so that a compare of the wrong width or wrong field shows up. Held matches, enable toggling, and a clear that arrives together with a new match test the edge detection and the set-over-clear priority apart from the compare.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
  } alarmStrobe_t;
endpackage

// File: rtl/cal_alarm_dp.sv
module cal_alarm_dp
  import cal_alarm_pkg::*;
#(
  parameter int SUBSEC_W = 15,
  parameter int CNT_W    = $clog2(SUBSEC_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [6:0]          curSec,
  input  logic [6:0]          curMin,
  input  logic [5:0]          curHour,
  input  logic                curPm,
  input  logic [5:0]          curDate,
  input  logic [3:0]          curWday,
  input  logic [SUBSEC_W-1:0] curSubSec,
  input  logic [6:0]          almSec,
  input  logic [6:0]          almMin,
  input  logic [5:0]          almHour,
  input  logic                almPm,
  input  logic [5:0]          almDay,
  input  logic                almWdSel,
  input  logic                maskSec,
  input  logic                maskMin,
  input  logic                maskHour,
  input  logic                maskDay,
  input  logic [SUBSEC_W-1:0] almSubSec,
  input  logic [CNT_W-1:0]    subSecBits,
  input  logic                irqEn,
  input  alarmStrobe_t        strb,
  output logic                rawMatch,
  output logic                almFlag,
  output logic                almIrq
);
  logic secHit, minHit, hourHit, dayHit, subSecHit;
  logic [SUBSEC_W-1:0] bitOk;
  logic flagQ;

  assign secHit  = maskSec  | (curSec == almSec);
  assign minHit  = maskMin  | (curMin == almMin);
  assign hourHit = maskHour | ((curHour == almHour) & (curPm == almPm));

  always_comb begin
    if (almWdSel) dayHit = maskDay | (curWday == almDay[3:0]);
    else          dayHit = maskDay | (curDate == almDay);
  end

  // One enable per sub-second bit: bit i takes part when i < subSecBits
  for (genvar i = 0; i < SUBSEC_W; i++) begin : g_subBit
    assign bitOk[i] = (32'(i) >= 32'(subSecBits)) | (curSubSec[i] == almSubSec[i]);
  end
  assign subSecHit = &bitOk;

  assign rawMatch = secHit & minHit & hourHit & dayHit & subSecHit;

  // Set takes priority over clear so that a fresh event is never lost
  always_ff @(posedge clk) begin
    if (!rstN)             flagQ <= 1'b0;
    else if (strb.setFlag) flagQ <= 1'b1;
    else if (strb.clrFlag) flagQ <= 1'b0;
  end

  assign almFlag = flagQ;
  assign almIrq  = flagQ & irqEn;
endmodule

// File: rtl/cal_alarm_ctrl.sv
module cal_alarm_ctrl
  import cal_alarm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rawMatch,
  input  logic         almEn,
  input  logic         clrStrobe,
  output alarmStrobe_t strb
);
  logic gatedMatch;
  logic prevGated;

  assign gatedMatch = rawMatch & almEn;

  always_ff @(posedge clk) begin
    if (!rstN) prevGated <= 1'b0;
    else       prevGated <= gatedMatch;
  end

  always_comb begin
    strb.setFlag = gatedMatch & ~prevGated;
    strb.clrFlag = clrStrobe;
  end
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter int SUBSEC_W = 15,
  parameter int CNT_W    = $clog2(SUBSEC_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [6:0]          curSec,
  input  logic [6:0]          curMin,
  input  logic [5:0]          curHour,
  input  logic                curPm,
  input  logic [5:0]          curDate,
  input  logic [3:0]          curWday,
  input  logic [SUBSEC_W-1:0] curSubSec,
  input  logic [6:0]          almSec,
  input  logic [6:0]          almMin,
  input  logic [5:0]          almHour,
  input  logic                almPm,
  input  logic [5:0]          almDay,
  input  logic                almWdSel,
  input  logic                maskSec,
  input  logic                maskMin,
  input  logic                maskHour,
  input  logic                maskDay,
  input  logic [SUBSEC_W-1:0] almSubSec,
  input  logic [CNT_W-1:0]    subSecBits,
  input  logic                almEn,
  input  logic                irqEn,
  input  logic                clrStrobe,
  output logic                almFlag,
  output logic                almIrq
);
  alarmStrobe_t strb;
  logic rawMatch;

  cal_alarm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rawMatch(rawMatch), .almEn(almEn),
    .clrStrobe(clrStrobe), .strb(strb)
  );

  cal_alarm_dp #(.SUBSEC_W(SUBSEC_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curPm(curPm),
    .curDate(curDate), .curWday(curWday), .curSubSec(curSubSec),
    .almSec(almSec), .almMin(almMin), .almHour(almHour), .almPm(almPm),
    .almDay(almDay), .almWdSel(almWdSel),
    .maskSec(maskSec), .maskMin(maskMin), .maskHour(maskHour), .maskDay(maskDay),
    .almSubSec(almSubSec), .subSecBits(subSecBits), .irqEn(irqEn),
    .strb(strb), .rawMatch(rawMatch), .almFlag(almFlag), .almIrq(almIrq)
  );
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk (
  input logic clk,
  input logic rstN,
  input logic almEn,
  input logic irqEn,
  input logic clrStrobe,
  input logic rawMatch,
  input logic almFlag,
  input logic almIrq
);
  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    almIrq |-> (almFlag && irqEn));

  p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rstN)
    (almFlag && irqEn) |-> almIrq);

  p_set_needs_enable_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(almFlag) |-> $past(almEn));

  p_set_needs_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(almFlag) |-> $past(rawMatch));

  p_disable_keeps_r9: assert property (@(posedge clk) disable iff (!rstN)
    (almFlag && !almEn && !clrStrobe) |=> almFlag);

  p_clear_works_r11: assert property (@(posedge clk) disable iff (!rstN)
    (clrStrobe && !almEn) |=> !almFlag);
endmodule

bind cal_alarm_cmp cal_alarm_chk u_chk (.*);

// File: tb/sim_cal_alarm_cmp.sv
`timescale 1ns/1ps
module sim_cal_alarm_cmp;
  localparam int SW = 15;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] curSec = 7'h00, curMin = 7'h00, almSec = 7'h30, almMin = 7'h15;
  logic [5:0] curHour = 6'h00, curDate = 6'h01, almHour = 6'h09, almDay = 6'h21;
  logic curPm = 1'b0, almPm = 1'b0, almWdSel = 1'b0;
  logic [3:0] curWday = 4'd1;
  logic [SW-1:0] curSubSec = '0, almSubSec = '0;
  logic [3:0] subSecBits = 4'd0;
  logic maskSec = 0, maskMin = 0, maskHour = 0, maskDay = 0;
  logic almEn = 0, irqEn = 0, clrStrobe = 0;
  logic almFlag, almIrq;

  int checks = 0, failures = 0;
  string curReq = "R1";
  bit finished = 0;
  bit mFlag = 0, mPrev = 0;

  always #10 clk = ~clk;

  cal_alarm_cmp u0 (.*);

  function automatic bit bcdEq(int a, int b, int unitsW);
    int ua = a % (1 << unitsW), ub = b % (1 << unitsW);
    return (ua == ub) && ((a >> unitsW) == (b >> unitsW));
  endfunction

  function automatic bit refMatch();
    bit ok = 1;
    int n = (int'(subSecBits) > SW) ? SW : int'(subSecBits);
    if (!maskSec && !bcdEq(curSec, almSec, 4)) ok = 0;
    if (!maskMin && !bcdEq(curMin, almMin, 4)) ok = 0;
    if (!maskHour && (!bcdEq(curHour, almHour, 4) || curPm != almPm)) ok = 0;
    if (!maskDay) begin
      if (almWdSel) begin
        if (int'(curWday) != int'(almDay) % 16) ok = 0;
      end else if (!bcdEq(curDate, almDay, 4)) ok = 0;
    end
    if (n > 0 && (int'(curSubSec) % (1 << n)) != (int'(almSubSec) % (1 << n))) ok = 0;
    return ok;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mFlag = 0; mPrev = 0;
    end else begin
      bit g;
      g = refMatch() && almEn;
      if (g && !mPrev) mFlag = 1;
      else if (clrStrobe) mFlag = 0;
      mPrev = g;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (almFlag !== mFlag || almIrq !== (mFlag & irqEn)) begin
        failures++;
        $display("FAIL %s cycle compare: flag=%0b irq=%0b expected flag=%0b irq=%0b",
                 curReq, almFlag, almIrq, mFlag, mFlag & irqEn);
      end
    end
  end

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic matchAll();
    curSec = almSec; curMin = almMin; curHour = almHour; curPm = almPm;
    curDate = almDay; curWday = almDay[3:0]; curSubSec = almSubSec;
  endtask

  task automatic pulseClear();
    clrStrobe = 1; cyc(1); clrStrobe = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=running expected=done");
    finish();
  end

  initial begin
    cyc(2);
    chk(almFlag, 0, "R1", "flag during reset");
    rstN = 1; cyc(1);
    chk(almFlag, 0, "R1", "flag after reset");
    chk(almIrq, 0, "R1", "irq after reset");

    almEn = 1; irqEn = 1;
    curReq = "R2"; matchAll(); cyc(1);
    chk(almFlag, 1, "R2", "full match sets flag");
    curReq = "R7"; cyc(1); pulseClear(); cyc(2);
    chk(almFlag, 0, "R7", "held match does not set again");

    curReq = "R2"; curSec = 7'h31; cyc(1); pulseClear(); cyc(1);
    chk(almFlag, 0, "R2", "seconds units mismatch");
    curSec = 7'h20; cyc(1); chk(almFlag, 0, "R2", "seconds tens mismatch");
    curReq = "R3"; maskSec = 1; cyc(1);
    chk(almFlag, 1, "R3", "seconds masked");
    pulseClear(); maskSec = 0; curSec = almSec; curMin = 7'h14; cyc(2);
    chk(almFlag, 0, "R3", "minutes compared");
    maskMin = 1; cyc(1); chk(almFlag, 1, "R3", "minutes masked");
    pulseClear(); maskMin = 0; curMin = almMin; curHour = 6'h19; cyc(2);
    maskHour = 1; cyc(1); chk(almFlag, 1, "R3", "hours masked");
    pulseClear(); maskHour = 0; curHour = almHour; curDate = 6'h22; cyc(2);
    chk(almFlag, 0, "R3", "day compared");
    maskDay = 1; cyc(1); chk(almFlag, 1, "R3", "day masked");
    pulseClear(); maskDay = 0; curDate = almDay; cyc(1);

    curReq = "R4"; curPm = 1; cyc(2);
    chk(almFlag, 0, "R4", "PM differs");
    almPm = 1; cyc(1); chk(almFlag, 1, "R4", "PM equal");
    pulseClear(); almPm = 0; curPm = 0; cyc(1);

    curReq = "R5"; curSec = 7'h00; cyc(1);
    almWdSel = 1; almDay = 6'h35; curWday = 4'd5; curDate = 6'h01; cyc(1);
    curSec = almSec; cyc(1);
    chk(almFlag, 1, "R5", "weekday match, date tens ignored");
    pulseClear(); curWday = 4'd6; cyc(2);
    chk(almFlag, 0, "R5", "weekday differs");
    almWdSel = 0; almDay = 6'h21; curDate = 6'h11; cyc(2);
    chk(almFlag, 0, "R5", "date tens compared");
    curDate = 6'h21; cyc(1); chk(almFlag, 1, "R5", "date match");
    pulseClear(); cyc(1);

    curReq = "R6"; curSec = 7'h00; almSubSec = 15'h1234; curSubSec = 15'h7FF4; cyc(1);
    subSecBits = 4'd4; curSec = almSec; cyc(1);
    chk(almFlag, 1, "R6", "low four bits match");
    pulseClear(); curSec = 7'h00; cyc(1);
    subSecBits = 4'd15; curSec = almSec; cyc(2);
    chk(almFlag, 0, "R6", "full width differs");
    curSubSec = 15'h1234; cyc(1); chk(almFlag, 1, "R6", "full width match");
    pulseClear(); curSubSec = 15'h1235; cyc(2);
    subSecBits = 4'd0; cyc(1); chk(almFlag, 1, "R6", "sub-second ignored");
    pulseClear(); cyc(1);

    curReq = "R8"; curSec = 7'h00; almEn = 0; cyc(1);
    curSec = almSec; cyc(2);
    chk(almFlag, 0, "R8", "disabled match");
    curReq = "R7"; almEn = 1; cyc(1);
    chk(almFlag, 1, "R7", "enable during match is an event");
    curReq = "R9"; almEn = 0; cyc(3);
    chk(almFlag, 1, "R9", "disable keeps flag");
    curReq = "R10"; irqEn = 0; cyc(1);
    chk(almIrq, 0, "R10", "irq masked");
    irqEn = 1; #1; chk(almIrq, 1, "R10", "irq passes flag");
    cyc(1);
    curReq = "R11"; pulseClear(); cyc(1);
    chk(almFlag, 0, "R11", "clear strobe");

    curReq = "R12"; almEn = 1; curSec = 7'h00; cyc(1);
    curSec = almSec; clrStrobe = 1; cyc(1); clrStrobe = 0;
    chk(almFlag, 1, "R12", "set beats clear");
    cyc(2);
    finish();
  end
endmodule